// File: doc/BRIEF.md
# Load/store port handshake controller

This block sits on the memory side of one load/store request port. A compute unit issues either a load or a store command. It then presents an address, and the controller answers once: it either grants the address or rejects it. A grant is a firm promise that the access will complete. A rejection means the access can never succeed. A single busy flag covers the whole transaction and falls on the exact cycle the transaction ends.

For a load, the read data comes back with a one-cycle valid pulse, a fixed number of cycles after the grant. For a store, the requester may raise a one-cycle write strobe with its data at any time after the grant. The memory takes that data without returning any acknowledgement.

Behind the controller is a small synchronous word-addressed memory that can be inferred as block RAM. Its read path has a configurable depth of pipeline registers. A new command may be presented in the same cycle that the previous transaction ends.

Top module: `lsport_ctrl`

## Requirements
- R1: A command is a cycle with exactly one of `ld_req_i` or `st_req_i` high while `busy_o` is low. `busy_o` is high in the cycle after such a command and stays high until the transaction ends.
- R2: A command presented while `busy_o` is high is ignored and is not queued. A cycle with `ld_req_i` and `st_req_i` both high is ignored, and `busy_o` stays low after it.
- R3: After a command, the first cycle with `addr_vld_i` high is answered in the next cycle by exactly one one-cycle pulse: `addr_ack_o` or `addr_exc_o`. `addr_vld_i` is ignored when no transaction is waiting for its address.
- R4: An address equal to or greater than DEPTH produces `addr_exc_o`. `busy_o` is low in that same cycle, and no access takes place.
- R5: An address below DEPTH produces `addr_ack_o` while `busy_o` stays high, and the access then always completes.
- R6: For a load, `rdata_vld_o` pulses for one cycle exactly RD_LAT cycles after the `addr_ack_o` cycle. `rdata_o` then carries the word last stored at that address, and `busy_o` is low in that cycle.
- R7: For a store, a `wstb_i` pulse in a cycle after the `addr_ack_o` cycle writes `wdata_i` to the granted address. `busy_o` is low during that strobe cycle.
- R8: A `wstb_i` pulse is ignored when no store has been granted. This covers idle cycles, the address phase and the `addr_ack_o` cycle itself. Memory contents are unchanged.
- R9: A command presented in the cycle a transaction ends is taken. The ending cycle is the `addr_exc_o` cycle, the `rdata_vld_o` cycle or the store-strobe cycle.
- R10: While synchronous active-high `rst` is high, and in the cycle after it, `busy_o`, `addr_ack_o`, `addr_exc_o` and `rdata_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_req_i | input | 1 | Load command |
| st_req_i | input | 1 | Store command |
| addr_vld_i | input | 1 | Address on `addr_i` is valid |
| addr_i | input | AW | Word address |
| wstb_i | input | 1 | One-cycle store data strobe |
| wdata_i | input | DW | Store data, valid with `wstb_i` |
| busy_o | output | 1 | Transaction in progress |
| addr_ack_o | output | 1 | Address granted; completion guaranteed |
| addr_exc_o | output | 1 | Address rejected; transaction ended |
| rdata_vld_o | output | 1 | Load data valid for this cycle only |
| rdata_o | output | DW | Load data |

## Verification
The end of one transaction and the start of the next can fall in the same cycle. Busy is low in the exception, load-data and store-strobe cycles, and the requester may present a new command in exactly those cycles. The bench raises a command in each of these three cycles. It then judges that busy is high in the following cycle and that the follow-on transaction runs to the expected grant and data. In the store case, it reads back the word written in the shared cycle, to confirm that the write was not lost when the new command was taken.

// File: rtl/lsport_pkg.sv
package lsport_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDR  = 2'd1,
    S_LOAD  = 2'd2,
    S_STORE = 2'd3
  } lsp_state_e;

endpackage

// File: rtl/lsport_addr_chk.sv
module lsport_addr_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 200
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_range_o
);

  generate
    if (DEPTH >= (2 ** AW)) begin : g_full
      // Every encodable address maps onto a word.
      logic unused_addr;
      assign unused_addr = ^addr_i;
      assign in_range_o  = 1'b1;
    end else begin : g_part
      localparam logic [AW-1:0] LIMIT = AW'(DEPTH);
      assign in_range_o = (addr_i < LIMIT);
    end
  endgenerate

endmodule

// File: rtl/lsport_mem.sv
module lsport_mem #(
  parameter int DW     = 32,
  parameter int DEPTH  = 200,
  parameter int RD_LAT = 2,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [IW-1:0] raddr_i,
  output logic          rvld_o,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] ram   [DEPTH];
  logic [DW-1:0] dpipe [RD_LAT];
  logic [RD_LAT-1:0] vpipe;

  // Array plus registered read: block-RAM template, no reset on data.
  always_ff @(posedge clk) begin
    if (we_i) ram[waddr_i] <= wdata_i;
    if (re_i) dpipe[0] <= ram[raddr_i];
    for (int i = 1; i < RD_LAT; i++) dpipe[i] <= dpipe[i-1];
  end

  generate
    if (RD_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= re_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[RD_LAT-2:0], re_i};
      end
    end
  endgenerate

  assign rvld_o  = vpipe[RD_LAT-1];
  assign rdata_o = dpipe[RD_LAT-1];

endmodule

// File: rtl/lsport_fsm.sv
module lsport_fsm
  import lsport_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req_i,
  input  logic          st_req_i,
  input  logic          addr_vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          in_range_i,
  input  logic          wstb_i,
  input  logic          mem_rvld_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] addr_q_o,
  output logic          busy_o,
  output logic          addr_ack_o,
  output logic          addr_exc_o,
  output logic          rdata_vld_o,
  output logic [DW-1:0] rdata_o
);

  lsp_state_e    state_q;
  logic          is_ld_q;
  logic          busy_q;
  logic          ack_q;
  logic          exc_q;
  logic          rvld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;

  logic cmd_one;
  logic st_fire;
  logic addr_go;

  assign cmd_one  = ld_req_i ^ st_req_i;
  // Strobe counts only strictly after the grant cycle.
  assign st_fire  = (state_q == S_STORE) && wstb_i && !ack_q;
  assign addr_go  = (state_q == S_ADDR) && addr_vld_i;
  assign mem_re_o = addr_go && in_range_i && is_ld_q;
  assign mem_we_o = st_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      is_ld_q <= 1'b0;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      exc_q   <= 1'b0;
      rvld_q  <= 1'b0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      ack_q  <= 1'b0;
      exc_q  <= 1'b0;
      rvld_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_one) begin
            state_q <= S_ADDR;
            busy_q  <= 1'b1;
            is_ld_q <= ld_req_i;
          end
        end
        S_ADDR: begin
          if (addr_vld_i) begin
            if (in_range_i) begin
              ack_q   <= 1'b1;
              addr_q  <= addr_i;
              state_q <= is_ld_q ? S_LOAD : S_STORE;
            end else begin
              exc_q   <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= S_IDLE;
            end
          end
        end
        S_LOAD: begin
          if (mem_rvld_i) begin
            rdata_q <= mem_rdata_i;
            rvld_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        S_STORE: begin
          if (st_fire) begin
            if (cmd_one) begin
              // Back-to-back: next command taken in the strobe cycle.
              state_q <= S_ADDR;
              busy_q  <= 1'b1;
              is_ld_q <= ld_req_i;
            end else begin
              state_q <= S_IDLE;
              busy_q  <= 1'b0;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Busy drops in the strobe cycle itself, so the store end is visible at once.
  assign busy_o      = busy_q & ~st_fire;
  assign addr_ack_o  = ack_q;
  assign addr_exc_o  = exc_q;
  assign rdata_vld_o = rvld_q;
  assign rdata_o     = rdata_q;
  assign addr_q_o    = addr_q;

endmodule

// File: rtl/lsport_ctrl.sv
module lsport_ctrl #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int DEPTH  = 200,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req_i,
  input  logic          st_req_i,
  input  logic          addr_vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wstb_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          addr_ack_o,
  output logic          addr_exc_o,
  output logic          rdata_vld_o,
  output logic [DW-1:0] rdata_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          in_range;
  logic          mem_re;
  logic          mem_we;
  logic          mem_rvld;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] addr_q;

  lsport_addr_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .addr_i     (addr_i),
    .in_range_o (in_range)
  );

  lsport_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ld_req_i    (ld_req_i),
    .st_req_i    (st_req_i),
    .addr_vld_i  (addr_vld_i),
    .addr_i      (addr_i),
    .in_range_i  (in_range),
    .wstb_i      (wstb_i),
    .mem_rvld_i  (mem_rvld),
    .mem_rdata_i (mem_rdata),
    .mem_re_o    (mem_re),
    .mem_we_o    (mem_we),
    .addr_q_o    (addr_q),
    .busy_o      (busy_o),
    .addr_ack_o  (addr_ack_o),
    .addr_exc_o  (addr_exc_o),
    .rdata_vld_o (rdata_vld_o),
    .rdata_o     (rdata_o)
  );

  lsport_mem #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .we_i    (mem_we),
    .waddr_i (addr_q[IW-1:0]),
    .wdata_i (wdata_i),
    .re_i    (mem_re),
    .raddr_i (addr_i[IW-1:0]),
    .rvld_o  (mem_rvld),
    .rdata_o (mem_rdata)
  );

endmodule

// File: rtl/lsport_ctrl_chk.sv
module lsport_ctrl_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 200
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_req_i,
  input logic          st_req_i,
  input logic [AW-1:0] addr_i,
  input logic          busy_o,
  input logic          addr_ack_o,
  input logic          addr_exc_o,
  input logic          rdata_vld_o
);

  p_busy_take_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && (ld_req_i ^ st_req_i)) |=> busy_o);

  p_both_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ld_req_i && st_req_i) |=> !busy_o);

  p_one_answer_r3: assert property (@(posedge clk) disable iff (rst)
    !(addr_ack_o && addr_exc_o));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    addr_ack_o |=> !addr_ack_o);

  p_exc_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    addr_exc_o |=> !addr_exc_o);

  p_exc_range_r4: assert property (@(posedge clk) disable iff (rst)
    addr_exc_o |-> (int'($past(addr_i)) >= DEPTH && !busy_o));

  p_ack_range_r5: assert property (@(posedge clk) disable iff (rst)
    addr_ack_o |-> (int'($past(addr_i)) < DEPTH && busy_o));

  p_rvld_end_r6: assert property (@(posedge clk) disable iff (rst)
    rdata_vld_o |-> !busy_o);

  p_rvld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rdata_vld_o |=> !rdata_vld_o);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !addr_ack_o && !addr_exc_o && !rdata_vld_o));

endmodule

bind lsport_ctrl lsport_ctrl_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .ld_req_i    (ld_req_i),
  .st_req_i    (st_req_i),
  .addr_i      (addr_i),
  .busy_o      (busy_o),
  .addr_ack_o  (addr_ack_o),
  .addr_exc_o  (addr_exc_o),
  .rdata_vld_o (rdata_vld_o)
);

// File: tb/lsport_ctrl_tb_top.sv
module lsport_ctrl_tb_top;

  localparam int AW      = 8;
  localparam int DW      = 32;
  localparam int DEPTH   = 200;
  localparam int RD_LAT  = 2;
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_req_i = 1'b0;
  logic          st_req_i = 1'b0;
  logic          addr_vld_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wstb_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic          busy_o, addr_ack_o, addr_exc_o, rdata_vld_o;
  logic [DW-1:0] rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_q [$];

  always #(CLK_PER/2) clk = ~clk;

  lsport_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) dut_i (
    .clk (clk), .rst (rst), .ld_req_i (ld_req_i), .st_req_i (st_req_i),
    .addr_vld_i (addr_vld_i), .addr_i (addr_i), .wstb_i (wstb_i),
    .wdata_i (wdata_i), .busy_o (busy_o), .addr_ack_o (addr_ack_o),
    .addr_exc_o (addr_exc_o), .rdata_vld_o (rdata_vld_o), .rdata_o (rdata_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor: pops expected load data when the design returns it.
  always @(negedge clk) begin
    if (!rst && rdata_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected load data", longint'(rdata_o), 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rdata_o == e, "R6", "load data", longint'(rdata_o), longint'(e));
      end
    end
  end

  task automatic issue_cmd(input bit is_ld);
    ld_req_i = is_ld;
    st_req_i = !is_ld;
    tick();
    ld_req_i = 1'b0;
    st_req_i = 1'b0;
    chk(busy_o == 1'b1, "R1", "busy after command", longint'(busy_o), 1);
  endtask

  task automatic give_addr(input logic [AW-1:0] a, input bit ok);
    addr_vld_i = 1'b1;
    addr_i     = a;
    tick();
    addr_vld_i = 1'b0;
    if (ok) begin
      chk(addr_ack_o && !addr_exc_o, "R5", "grant pulse", longint'({addr_ack_o, addr_exc_o}), 2);
      chk(busy_o == 1'b1, "R5", "busy held on grant", longint'(busy_o), 1);
    end else begin
      chk(addr_exc_o && !addr_ack_o, "R4", "exception pulse", longint'({addr_ack_o, addr_exc_o}), 1);
      chk(busy_o == 1'b0, "R4", "busy low with exception", longint'(busy_o), 0);
    end
  endtask

  // Starts in the grant cycle, ends in the data cycle.
  task automatic finish_load(input logic [AW-1:0] a);
    exp_q.push_back(model[a]);
    for (int i = 0; i < RD_LAT; i++) begin
      chk(rdata_vld_o == 1'b0, "R6", "no early data", longint'(rdata_vld_o), 0);
      tick();
    end
    chk(rdata_vld_o == 1'b1, "R6", "data after latency", longint'(rdata_vld_o), 1);
    chk(busy_o == 1'b0, "R6", "busy low with data", longint'(busy_o), 0);
  endtask

  task automatic do_strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wstb_i  = 1'b1;
    wdata_i = d;
    #1;
    chk(busy_o == 1'b0, "R7", "busy low in strobe cycle", longint'(busy_o), 0);
    model[a] = d;
    tick();
    wstb_i = 1'b0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue_cmd(1'b0);
    give_addr(a, 1'b1);
    tick();
    do_strobe(a, d);
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    issue_cmd(1'b1);
    give_addr(a, 1'b1);
    finish_load(a);
  endtask

  initial begin
    repeat (3) tick();
    chk(!busy_o && !addr_ack_o && !addr_exc_o && !rdata_vld_o, "R10", "reset outputs",
        longint'({busy_o, addr_ack_o, addr_exc_o, rdata_vld_o}), 0);
    rst = 1'b0;
    tick();
    chk(busy_o == 1'b0, "R10", "idle after reset", longint'(busy_o), 0);

    // Basic store then load, plus the last valid word.
    do_store(8'd5, 32'hA5A5_0001);
    do_load(8'd5);
    tick();
    do_store(8'd199, 32'h0BAD_F00D);
    do_load(8'd199);

    // R4: first and top out-of-range addresses, both commands.
    tick();
    issue_cmd(1'b1);
    give_addr(8'd200, 1'b0);
    tick();
    issue_cmd(1'b0);
    give_addr(8'd255, 1'b0);

    // R8: stray strobe while idle must not write.
    tick();
    wstb_i = 1'b1; wdata_i = 32'hDEAD_0000;
    tick();
    wstb_i = 1'b0;
    chk(busy_o == 1'b0, "R8", "idle strobe no busy", longint'(busy_o), 0);
    do_load(8'd199);

    // R8: strobes in the address phase and grant cycle are ignored.
    tick();
    issue_cmd(1'b0);
    addr_vld_i = 1'b1; addr_i = 8'd10; wstb_i = 1'b1; wdata_i = 32'h1111_1111;
    tick();
    addr_vld_i = 1'b0;
    wdata_i = 32'h2222_2222;
    #1;
    chk(busy_o == 1'b1, "R8", "grant-cycle strobe ignored", longint'(busy_o), 1);
    tick();
    wstb_i = 1'b0;
    do_strobe(8'd10, 32'h3333_3333);
    do_load(8'd10);

    // R2: both commands together are ignored; address-valid when idle ignored.
    tick();
    ld_req_i = 1'b1; st_req_i = 1'b1;
    tick();
    ld_req_i = 1'b0; st_req_i = 1'b0;
    chk(busy_o == 1'b0, "R2", "dual command ignored", longint'(busy_o), 0);
    addr_vld_i = 1'b1; addr_i = 8'd3;
    tick();
    addr_vld_i = 1'b0;
    chk(!addr_ack_o && !addr_exc_o, "R3", "idle address ignored",
        longint'({addr_ack_o, addr_exc_o}), 0);

    // R2: command while busy is dropped.
    issue_cmd(1'b0);
    give_addr(8'd20, 1'b1);
    st_req_i = 1'b1;
    tick();
    st_req_i = 1'b0;
    do_strobe(8'd20, 32'h4444_4444);
    tick();
    chk(busy_o == 1'b0, "R2", "busy-time command not queued", longint'(busy_o), 0);

    // R9: new command in the load-data cycle.
    issue_cmd(1'b1);
    give_addr(8'd20, 1'b1);
    finish_load(8'd20);
    issue_cmd(1'b0);
    give_addr(8'd30, 1'b1);
    tick();
    // R9: new command in the store-strobe cycle.
    ld_req_i = 1'b1;
    do_strobe(8'd30, 32'h5555_5555);
    ld_req_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "command taken in strobe cycle", longint'(busy_o), 1);
    give_addr(8'd30, 1'b1);
    finish_load(8'd30);
    // R9: new command in the exception cycle.
    tick();
    issue_cmd(1'b0);
    give_addr(8'd222, 1'b0);
    issue_cmd(1'b1);
    give_addr(8'd5, 1'b1);
    finish_load(8'd5);

    repeat (3) tick();
    chk(exp_q.size() == 0, "R6", "all loads returned", longint'(exp_q.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule